// File: doc/BRIEF.md
# Enable-Paced Repeated-Subtraction Divider

This block divides a wide unsigned dividend by an unsigned divisor of the same width. It does so by subtracting the divisor from a working remainder over and over, and it counts each subtraction in the quotient. Before the division starts, the dividend is moved left by a fixed number of bit positions. The quotient therefore carries that many fractional bits. The default widths are a 112-bit operand and 6 fractional bits.

The compare and subtract act only when an internal tick is high. The tick repeats once every `EN_PERIOD` clocks, and its counter is cleared when a start is accepted. Between ticks, every datapath register holds its value. This lets the wide subtractor be constrained as a multicycle path.

A division begins with a single-cycle `start_i` pulse, and the operands are sampled on that cycle only. When the remainder is no longer at least the divisor, the block raises `done_o` for one cycle. The results then stay valid until the next accepted start. A zero divisor finishes on the very next cycle and raises a flag.

Top module: `slow_sub_divider`

## Requirements
- R1: Operands are `DATA_W` bits wide. The quotient and remainder are `DATA_W+FRAC_W` bits wide, so full-width operands give exact results.
- R2: With a nonzero divisor, the final quotient equals floor((dividend·2^FRAC_W)/divisor) and the final remainder equals (dividend·2^FRAC_W) mod divisor. At completion, the remainder is below the divisor.
- R3: The quotient and remainder change during a division only on tick cycles. Each tick with remainder ≥ divisor subtracts once and adds exactly one to the quotient.
- R4: With quotient Q, `done_o` rises exactly (Q+1)·EN_PERIOD clock edges after the edge that accepts the start. The default EN_PERIOD is 2.
- R5: `busy_o` is high from the edge after an accepted start until the completion edge. `done_o` is a one-cycle pulse and is never high together with `busy_o`.
- R6: While the block is idle and no start arrives, the quotient, remainder and flag hold their values.
- R7: A start that arrives while busy is ignored. Operand inputs are sampled only on an accepted start, and later changes to them have no effect on the running division.
- R8: With a zero divisor, `done_o` rises on the edge after the start, `dbz_o` is 1, the quotient is all ones, the remainder is the shifted dividend, and `busy_o` stays low.
- R9: `dbz_o` is rewritten on every accepted start, so it is 0 after a division with a nonzero divisor.
- R10: After reset, `busy_o`, `done_o` and `dbz_o` are 0 and the quotient and remainder are 0.
- R11: When the shifted dividend is below the divisor, the quotient is 0, the remainder is the shifted dividend, and `done_o` rises EN_PERIOD edges after the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, accepted only when idle |
| dividend_i | input | DATA_W | Unsigned dividend |
| divisor_i | input | DATA_W | Unsigned divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dbz_o | output | 1 | Last division had a zero divisor |
| quotient_o | output | DATA_W+FRAC_W | Quotient with FRAC_W fractional bits |
| remainder_o | output | DATA_W+FRAC_W | Remainder of the shifted dividend |

## Verification
The assertions assume that `start_i` is a single-cycle pulse and that a start is not requested on the cycle `done_o` is high. They also assume that no start arrives during the internal reset release. The bench keeps to these rules: it waits several cycles after reset and after every completion before issuing a start. It also chooses operands whose quotients stay below about a thousand, so that the paced run finishes within its time limit. Full-width operands are still used, by pairing a large dividend with a divisor of similar size.

// File: rtl/sub_div_pkg.sv
`timescale 1ns/1ps
package sub_div_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/sub_div_rst_sync.sv
`timescale 1ns/1ps
module sub_div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/sub_div_tick.sv
`timescale 1ns/1ps
module sub_div_tick #(
  parameter int PERIOD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear_i | run_i;
    if (clear_i)             cnt_d = '0;
    else if (cnt_q == LAST)  cnt_d = '0;
    else                     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tick_o = run_i & (cnt_q == LAST);
endmodule

// File: rtl/sub_div_datapath.sv
`timescale 1ns/1ps
module sub_div_datapath #(
  parameter int DATA_W = 112,
  parameter int FRAC_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic                     zero_i,
  input  logic                     step_i,
  input  logic [DATA_W-1:0]        dividend_i,
  input  logic [DATA_W-1:0]        divisor_i,
  output logic                     ge_o,
  output logic [DATA_W+FRAC_W-1:0] rem_o,
  output logic [DATA_W+FRAC_W-1:0] quo_o,
  output logic [DATA_W-1:0]        div_o,
  output logic                     dbz_o
);
  localparam int W = DATA_W + FRAC_W;

  logic [W-1:0]      rem_q, rem_d;
  logic [W-1:0]      quo_q, quo_d;
  logic [DATA_W-1:0] div_q, div_d;
  logic              dbz_q, dbz_d;
  logic [W-1:0]      div_ext;
  logic              reg_en;

  assign div_ext = {{FRAC_W{1'b0}}, div_q};
  assign ge_o    = (rem_q >= div_ext);
  assign reg_en  = load_i | step_i;

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    div_d = div_q;
    dbz_d = dbz_q;
    if (load_i) begin
      rem_d = {dividend_i, {FRAC_W{1'b0}}};
      div_d = divisor_i;
      dbz_d = zero_i;
      quo_d = zero_i ? '1 : '0;
    end else if (step_i) begin
      rem_d = rem_q - div_ext;
      quo_d = quo_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      div_q <= '0;
      dbz_q <= 1'b0;
    end else if (reg_en) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      div_q <= div_d;
      dbz_q <= dbz_d;
    end
  end

  assign rem_o = rem_q;
  assign quo_o = quo_q;
  assign div_o = div_q;
  assign dbz_o = dbz_q;
endmodule

// File: rtl/sub_div_ctrl.sv
`timescale 1ns/1ps
module sub_div_ctrl
  import sub_div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic zero_i,
  input  logic tick_i,
  input  logic ge_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  div_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          if (zero_i) done_d  = 1'b1;
          else        state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (tick_i) begin
          if (ge_i) begin
            step_o = 1'b1;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/slow_sub_divider.sv
`timescale 1ns/1ps
module slow_sub_divider #(
  parameter int DATA_W    = 112,
  parameter int FRAC_W    = 6,
  parameter int EN_PERIOD = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [DATA_W-1:0]        dividend_i,
  input  logic [DATA_W-1:0]        divisor_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     dbz_o,
  output logic [DATA_W+FRAC_W-1:0] quotient_o,
  output logic [DATA_W+FRAC_W-1:0] remainder_o
);
  logic              rst_n_s;
  logic              load_w;
  logic              step_w;
  logic              tick_w;
  logic              ge_w;
  logic              zero_w;
  logic [DATA_W-1:0] div_w;

  assign zero_w = (divisor_i == '0);

  sub_div_rst_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  sub_div_tick #(.PERIOD(EN_PERIOD)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clear_i (load_w),
    .run_i   (busy_o),
    .tick_o  (tick_w)
  );

  sub_div_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (start_i),
    .zero_i  (zero_w),
    .tick_i  (tick_w),
    .ge_i    (ge_w),
    .load_o  (load_w),
    .step_o  (step_w),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  sub_div_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (load_w),
    .zero_i     (zero_w),
    .step_i     (step_w),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .ge_o       (ge_w),
    .rem_o      (remainder_o),
    .quo_o      (quotient_o),
    .div_o      (div_w),
    .dbz_o      (dbz_o)
  );
endmodule

// File: rtl/slow_sub_divider_chk.sv
`timescale 1ns/1ps
module slow_sub_divider_chk #(
  parameter int DATA_W = 112,
  parameter int FRAC_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic                     dbz_o,
  input logic [DATA_W+FRAC_W-1:0] quotient_o,
  input logic [DATA_W+FRAC_W-1:0] remainder_o,
  input logic                     tick_i,
  input logic [DATA_W-1:0]        div_i
);
  localparam int W = DATA_W + FRAC_W;
  logic [W-1:0] div_ext;
  assign div_ext = {{FRAC_W{1'b0}}, div_i};

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !done_o);

  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(quotient_o) && $stable(remainder_o) && $stable(dbz_o));

  assert_no_step_off_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !tick_i |=> $stable(quotient_o) && $stable(remainder_o));

  assert_step_adds_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && tick_i && (remainder_o >= div_ext) |=> quotient_o == $past(quotient_o) + W'(1));

  assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(div_i));

  assert_zero_div_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && dbz_o |-> (&quotient_o));

  assert_final_rem_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !dbz_o |-> remainder_o < div_ext);
endmodule

bind slow_sub_divider slow_sub_divider_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .dbz_o       (dbz_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .tick_i      (tick_w),
  .div_i       (div_w)
);

// File: tb/slow_sub_divider_tb_top.sv
`timescale 1ns/1ps
module slow_sub_divider_tb_top;
  localparam int DW = 112;
  localparam int FW = 6;
  localparam int W  = DW + FW;
  localparam int P  = 2;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [DW-1:0] dividend_i;
  logic [DW-1:0] divisor_i;
  logic          busy_o, done_o, dbz_o;
  logic [W-1:0]  quotient_o, remainder_o;

  slow_sub_divider #(.DATA_W(DW), .FRAC_W(FW), .EN_PERIOD(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .dbz_o(dbz_o),
    .quotient_o(quotient_o), .remainder_o(remainder_o));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  bit    finished = 0;
  string cur_tag = "R10";

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model, updated on every rising edge
  bit           m_busy, m_done, m_dbz;
  logic [W-1:0] m_q, m_r, pend_q, pend_r;
  int           m_cd;
  longint       cyc = 0, start_cyc = 0, exp_lat = 0;
  bit           lat_valid;

  always @(posedge clk) begin
    cyc++;
    m_done = 0;
    if (!rst_n) begin
      m_busy = 0; m_dbz = 0; m_q = '0; m_r = '0; m_cd = 0; lat_valid = 0;
    end else if (m_busy) begin
      m_cd--;
      if (m_cd == 0) begin
        m_busy = 0; m_done = 1; m_q = pend_q; m_r = pend_r;
      end
    end else if (start_i) begin
      logic [W-1:0] sh;
      sh = {dividend_i, {FW{1'b0}}};
      start_cyc = cyc;
      if (divisor_i == '0) begin
        m_done = 1; m_dbz = 1; m_q = '1; m_r = sh; lat_valid = 0;
      end else begin
        m_dbz  = 0;
        pend_q = sh / {{FW{1'b0}}, divisor_i};
        pend_r = sh % {{FW{1'b0}}, divisor_i};
        m_busy = 1;
        m_cd   = (int'(pend_q) + 1) * P;
        exp_lat = m_cd;
        lat_valid = 1;
      end
    end
  end

  // compare on every falling edge
  logic [W-1:0] prev_q;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5 busy", {127'b0, busy_o}, {127'b0, m_busy});
      chk("R5 done", {127'b0, done_o}, {127'b0, m_done});
      if (!m_busy) begin
        chk({cur_tag, " quotient"}, 128'(quotient_o), 128'(m_q));
        chk({cur_tag, " remainder"}, 128'(remainder_o), 128'(m_r));
        chk("R9 dbz", {127'b0, dbz_o}, {127'b0, m_dbz});
      end else if (quotient_o !== prev_q && cyc != start_cyc) begin
        chk("R3 step on tick", 128'((cyc - start_cyc) % P), 128'(0));
      end
      if (done_o && lat_valid)
        chk("R4 latency", 128'(cyc - start_cyc), 128'(exp_lat));
    end
    prev_q = quotient_o;
  end

  task automatic go(input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk);
    start_i = 1; dividend_i = a; divisor_i = b;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 busy", {127'b0, busy_o}, 128'd0);
    chk("R10 done", {127'b0, done_o}, 128'd0);
    chk("R10 dbz",  {127'b0, dbz_o},  128'd0);
    chk("R10 quotient", 128'(quotient_o), 128'd0);

    // R2: 6400/7 -> 914 rem 2, also R4 latency and R3 stepping
    cur_tag = "R2";
    go(112'd100, 112'd7);
    wait_done();
    chk("R2 quotient", 128'(quotient_o), 128'd914);
    chk("R2 remainder", 128'(remainder_o), 128'd2);

    // R1: full-width operands, dividend == divisor with top bit set -> 64 rem 0
    cur_tag = "R1";
    go({1'b1, 111'h1234_5678_9abc_def0_1122_3344_5566}, {1'b1, 111'h1234_5678_9abc_def0_1122_3344_5566});
    wait_done();
    chk("R1 quotient", 128'(quotient_o), 128'd64);
    chk("R1 remainder", 128'(remainder_o), 128'd0);

    // R1: large dividend, divisor a bit smaller
    go({1'b1, 111'h0}, {2'b01, 110'h3});
    wait_done();

    // R11: shifted dividend below divisor
    cur_tag = "R11";
    go(112'd3, 112'd500);
    wait_done();
    chk("R11 quotient", 128'(quotient_o), 128'd0);
    chk("R11 remainder", 128'(remainder_o), 128'd192);
    go(112'd0, 112'd5);
    wait_done();

    // R7: start during busy and changing operands are ignored; 6400/9 -> 711 rem 1
    cur_tag = "R7";
    go(112'd100, 112'd9);
    repeat (20) @(negedge clk);
    start_i = 1; dividend_i = 112'd5; divisor_i = 112'd1;
    @(negedge clk);
    start_i = 0; divisor_i = 112'd3;
    wait_done();
    chk("R7 quotient", 128'(quotient_o), 128'd711);
    chk("R7 remainder", 128'(remainder_o), 128'd1);

    // R8: zero divisor
    cur_tag = "R8";
    go(112'd77, 112'd0);
    chk("R8 done", {127'b0, done_o}, 128'd1);
    chk("R8 dbz", {127'b0, dbz_o}, 128'd1);
    chk("R8 busy", {127'b0, busy_o}, 128'd0);
    chk("R8 quotient", 128'(quotient_o), 128'({W{1'b1}}));
    chk("R8 remainder", 128'(remainder_o), 128'(77 * 64));

    // R6: idle hold with changing inputs and no start
    cur_tag = "R6";
    dividend_i = 112'd9; divisor_i = 112'd2;
    repeat (10) @(negedge clk);
    chk("R6 quotient hold", 128'(quotient_o), 128'({W{1'b1}}));
    chk("R6 remainder hold", 128'(remainder_o), 128'(77 * 64));

    // R9: flag cleared by a normal division; 64*50/64 -> 50 rem 0
    cur_tag = "R9";
    go(112'd50, 112'd64);
    wait_done();
    chk("R9 dbz cleared", {127'b0, dbz_o}, 128'd0);
    chk("R9 quotient", 128'(quotient_o), 128'd50);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule